// File: doc/BRIEF.md
# Programmable Trigger Condition Evaluator

This block watches a vector of sampled probe signals and decides, on every clock cycle, whether a programmed trigger condition holds. Several comparator slots each pick a field out of the probe vector, either a bus field of fixed width starting at a programmable bit offset or one single bit. Each slot tests that field against programmed constants with one of six tests. The slot results meet in two equations, a conjunction over the slots picked by one mask and a disjunction over the slots picked by another. A combine selector uses one equation alone or joins both.

All of the setup sits in registers loaded through a simple write port: operators, constants, offsets, masks, combine selector and capture mode. It can be rewritten at any time while the block runs. Only the probe bits that a build-time source mask marks as trigger sources reach the comparators. The result is a registered trigger pulse. In repeating mode the pulse is raised on every cycle the condition holds. In single-shot mode the first hit disarms the block until a re-arm strobe is written.

Top module: `trig_eval`

## Requirements
- R1: Slot select register (offset 4+4s for slot s) holds the operator in bits [2:0], the bit-mode flag in bit 3 and the field offset in bits [15:8]. Operator code 0 hits when the field equals constant A (offset 5+4s) and code 1 hits when it differs. Codes 6 and 7 never hit.
- R2: Operator code 2 hits when the field is below A and code 3 hits when it is above A. Both compare as unsigned numbers.
- R3: Operator code 4 hits when A <= field <= constant B (offset 6+4s), both bounds included. Code 5 hits exactly when code 4 would not.
- R4: When bit mode is 0, the field is FIELD_W probe bits starting at the offset, with zeros beyond the top of the probe. When bit mode is 1, the field is the single probe bit at the offset, zero-extended.
- R5: Probe bits outside the SRC_MASK parameter read as zero at every comparator.
- R6: The AND term is true when every slot enabled in the AND mask (offset 1, bit s for slot s) hits. It is false when that mask is zero.
- R7: The OR term is true when any slot enabled in the OR mask (offset 2) hits. Control bits [2:1] (offset 0) select the trigger: 0 for the AND term, 1 for the OR term, 2 for AND or OR, 3 for AND and OR.
- R8: The trigger output rises in the cycle after the probe value that satisfies the condition.
- R9: With control bit 0 clear (single shot), a trigger disarms the block and later hits are ignored. Writing control bit 8 as 1 re-arms the block, and the re-arm wins over a trigger in the same cycle.
- R10: With control bit 0 set (repeat), the trigger is high for every cycle whose probe value satisfies the condition.
- R11: After reset the trigger output is low, both masks are zero and the block is armed.
- R12: A register write takes effect for probe values presented in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_i | input | PROBE_W | Sampled probe signals |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register word address |
| wr_data_i | input | 32 | Register write data |
| trig_o | output | 1 | Registered trigger pulse |

## Verification
The hardest state to reach is a single-shot block that has already fired while its condition still holds. Only that state can show that later hits are dropped and that only the re-arm strobe restores firing. The bench holds a matching probe across several cycles after the first pulse, then writes the re-arm strobe with a non-matching probe and presents the match again. The mixed AND/OR combine modes also need two slots set to hit on disjoint fields, so that each equation can be made true on its own.

// File: rtl/trig_pkg.sv
// Shared encodings for the trigger evaluator.
// Assumes: register word width of 32 bits, field offsets up to 255.
package trig_pkg;
    localparam int REG_W = 32;

    localparam logic [2:0] OP_EQ  = 3'd0;
    localparam logic [2:0] OP_NE  = 3'd1;
    localparam logic [2:0] OP_LT  = 3'd2;
    localparam logic [2:0] OP_GT  = 3'd3;
    localparam logic [2:0] OP_IN  = 3'd4;
    localparam logic [2:0] OP_OUT = 3'd5;

    localparam logic [1:0] CMB_AND  = 2'd0;
    localparam logic [1:0] CMB_OR   = 2'd1;
    localparam logic [1:0] CMB_ANY  = 2'd2;
    localparam logic [1:0] CMB_BOTH = 2'd3;

    typedef struct packed {
        logic [7:0] lsb;
        logic       bit_mode;
        logic [2:0] op;
    } slot_sel_t;
endpackage

// File: rtl/trig_regs.sv
// Configuration registers loaded through a plain write port.
// Map: 0 control, 1 AND mask, 2 OR mask, 4+4s select, 5+4s const A, 6+4s const B.
// Assumes: one write per cycle; the re-arm bit is a strobe, not stored.
module trig_regs
    import trig_pkg::*;
#(
    parameter int NSLOT   = 4,
    parameter int FIELD_W = 16,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    output logic               repeat_q,
    output logic [1:0]         comb_q,
    output logic [NSLOT-1:0]   and_mask_q,
    output logic [NSLOT-1:0]   or_mask_q,
    output slot_sel_t          sel_q [NSLOT],
    output logic [FIELD_W-1:0] a_q   [NSLOT],
    output logic [FIELD_W-1:0] b_q   [NSLOT],
    output logic               rearm
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_AND  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_OR   = ADDR_W'(2);

    // Re-arm strobe: a control write with bit 8 set.
    assign rearm = wr_en && (wr_addr == A_CTRL) && wr_data[8];

    // Global control and the two equation masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            repeat_q   <= 1'b0;
            comb_q     <= CMB_AND;
            and_mask_q <= '0;
            or_mask_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                repeat_q <= wr_data[0];
                comb_q   <= wr_data[2:1];
            end
            if (wr_addr == A_AND) and_mask_q <= wr_data[NSLOT-1:0];
            if (wr_addr == A_OR)  or_mask_q  <= wr_data[NSLOT-1:0];
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic blk_hit;
        assign blk_hit = wr_en && (wr_addr[ADDR_W-1:2] == (ADDR_W-2)'(s + 1));

        // Per-slot select and constants.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[s] <= '0;
                a_q[s]   <= '0;
                b_q[s]   <= '0;
            end else if (blk_hit) begin
                case (wr_addr[1:0])
                    2'd0:    sel_q[s] <= slot_sel_t'({wr_data[15:8], wr_data[3], wr_data[2:0]});
                    2'd1:    a_q[s]   <= wr_data[FIELD_W-1:0];
                    2'd2:    b_q[s]   <= wr_data[FIELD_W-1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/trig_slot.sv
// One comparator slot: picks a field or one bit out of the probe and
// tests it against constants A and B. Purely combinational result.
// Assumes: FIELD_W <= PROBE_W; probe already reduced to trigger sources.
module trig_slot
    import trig_pkg::*;
#(
    parameter int PROBE_W = 32,
    parameter int FIELD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PROBE_W-1:0] probe,
    input  slot_sel_t          sel,
    input  logic [FIELD_W-1:0] a,
    input  logic [FIELD_W-1:0] b,
    output logic               hit
);
    logic [PROBE_W-1:0] shifted;
    logic [FIELD_W-1:0] field;
    logic               in_rng;

    // Field extraction: bus slice or zero-extended single bit.
    always_comb begin
        shifted = probe >> sel.lsb;
        field   = sel.bit_mode ? {{(FIELD_W-1){1'b0}}, shifted[0]} : shifted[FIELD_W-1:0];
    end

    // Operator evaluation.
    always_comb begin
        in_rng = (field >= a) && (field <= b);
        case (sel.op)
            OP_EQ:   hit = (field == a);
            OP_NE:   hit = (field != a);
            OP_LT:   hit = (field < a);
            OP_GT:   hit = (field > a);
            OP_IN:   hit = in_rng;
            OP_OUT:  hit = !in_rng;
            default: hit = 1'b0;
        endcase
    end

    // R3
    empty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.op == OP_IN && a > b) |-> !hit);
    // R1
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.op > OP_OUT) |-> !hit);
endmodule

// File: rtl/trig_combine.sv
// Joins slot hits through the AND and OR equations, applies arming and
// registers the trigger pulse.
// Assumes: masks, combine selector and mode come from registers.
module trig_combine
    import trig_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] hits,
    input  logic [NSLOT-1:0] and_mask,
    input  logic [NSLOT-1:0] or_mask,
    input  logic [1:0]       comb,
    input  logic             repeat_mode,
    input  logic             rearm,
    output logic             trig_q
);
    logic and_term, or_term, cond, fire, armed_q;

    // Equation terms and the combine selector.
    always_comb begin
        and_term = (and_mask != '0) && ((hits & and_mask) == and_mask);
        or_term  = |(hits & or_mask);
        case (comb)
            CMB_AND:  cond = and_term;
            CMB_OR:   cond = or_term;
            CMB_ANY:  cond = and_term | or_term;
            default:  cond = and_term & or_term;
        endcase
        fire = cond && armed_q;
    end

    // Arming state: re-arm strobe wins, single-shot fire disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)                    armed_q <= 1'b1;
        else if (rearm)                armed_q <= 1'b1;
        else if (fire && !repeat_mode) armed_q <= 1'b0;
    end

    // Registered trigger output.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= fire;
    end

    // R9
    fire_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> $past(armed_q));
    // R9
    one_shot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !repeat_mode && !rearm) |=> !armed_q);
    // R9
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> armed_q);
    // R6
    no_mask_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (and_mask == '0 && or_mask == '0) |=> !trig_q);
endmodule

// File: rtl/trig_eval.sv
// Top of the trigger evaluator: source masking, register file,
// comparator slots and the combine/arm stage.
// Assumes: probe_i is already sampled in the clk domain.
module trig_eval
    import trig_pkg::*;
#(
    parameter int                   PROBE_W  = 32,
    parameter int                   FIELD_W  = 16,
    parameter int                   NSLOT    = 4,
    parameter logic [PROBE_W-1:0]   SRC_MASK = 32'h00FF_FFFF,
    localparam int                  ADDR_W   = $clog2(4 + 4 * NSLOT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PROBE_W-1:0] probe_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [31:0]        wr_data_i,
    output logic               trig_o
);
    logic               repeat_q, rearm;
    logic [1:0]         comb_q;
    logic [NSLOT-1:0]   and_mask_q, or_mask_q, hits;
    slot_sel_t          sel_q [NSLOT];
    logic [FIELD_W-1:0] a_q   [NSLOT];
    logic [FIELD_W-1:0] b_q   [NSLOT];
    logic [PROBE_W-1:0] src;

    // Only configured trigger sources reach the comparators.
    assign src = probe_i & SRC_MASK;

    trig_regs #(.NSLOT(NSLOT), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .repeat_q(repeat_q), .comb_q(comb_q),
        .and_mask_q(and_mask_q), .or_mask_q(or_mask_q), .sel_q(sel_q),
        .a_q(a_q), .b_q(b_q), .rearm(rearm)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
        trig_slot #(.PROBE_W(PROBE_W), .FIELD_W(FIELD_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .probe(src), .sel(sel_q[s]),
            .a(a_q[s]), .b(b_q[s]), .hit(hits[s])
        );
    end

    trig_combine #(.NSLOT(NSLOT)) u_comb (
        .clk(clk), .rst_n(rst_n), .hits(hits), .and_mask(and_mask_q),
        .or_mask(or_mask_q), .comb(comb_q), .repeat_mode(repeat_q),
        .rearm(rearm), .trig_q(trig_o)
    );
endmodule

// File: tb/test_trig_eval.sv
module test_trig_eval;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] probe = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        trig;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    trig_eval i_trig_eval (
        .clk(clk), .rst_n(rst_n), .probe_i(probe), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .trig_o(trig)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [2:0]  op;
        logic        bm;
        logic [7:0]  lsb;
        logic [15:0] a;
        logic [15:0] b;
        logic [31:0] p;
        logic        exp;
    } vec_t;

    // Slot 0 alone, AND mask = 1, repeat mode.
    localparam vec_t TBL [17] = '{
        '{3'd0, 1'b0, 8'd0,  16'h1234, 16'h0000, 32'h0000_1234, 1'b1}, // R1 eq
        '{3'd0, 1'b0, 8'd0,  16'h1234, 16'h0000, 32'h0000_1235, 1'b0}, // R1 eq miss
        '{3'd1, 1'b0, 8'd0,  16'h1234, 16'h0000, 32'h0000_1235, 1'b1}, // R1 ne
        '{3'd2, 1'b0, 8'd0,  16'h0100, 16'h0000, 32'h0000_00FF, 1'b1}, // R2 lt
        '{3'd2, 1'b0, 8'd0,  16'h0100, 16'h0000, 32'h0000_0100, 1'b0}, // R2 lt edge
        '{3'd3, 1'b0, 8'd0,  16'h0100, 16'h0000, 32'h0000_0101, 1'b1}, // R2 gt
        '{3'd4, 1'b0, 8'd0,  16'h0010, 16'h0020, 32'h0000_0010, 1'b1}, // R3 low bound
        '{3'd4, 1'b0, 8'd0,  16'h0010, 16'h0020, 32'h0000_0020, 1'b1}, // R3 high bound
        '{3'd4, 1'b0, 8'd0,  16'h0010, 16'h0020, 32'h0000_0021, 1'b0}, // R3 above
        '{3'd5, 1'b0, 8'd0,  16'h0010, 16'h0020, 32'h0000_000F, 1'b1}, // R3 outside
        '{3'd5, 1'b0, 8'd0,  16'h0010, 16'h0020, 32'h0000_0015, 1'b0}, // R3 inside
        '{3'd0, 1'b1, 8'd5,  16'h0001, 16'h0000, 32'h0000_0020, 1'b1}, // R4 bit set
        '{3'd0, 1'b1, 8'd5,  16'h0001, 16'h0000, 32'h0000_0000, 1'b0}, // R4 bit clear
        '{3'd0, 1'b0, 8'd8,  16'h00AB, 16'h0000, 32'h0000_AB00, 1'b1}, // R4 offset
        '{3'd0, 1'b0, 8'd16, 16'h00CD, 16'h0000, 32'hFFCD_0000, 1'b1}, // R5 masked top
        '{3'd0, 1'b0, 8'd16, 16'hFFCD, 16'h0000, 32'hFFCD_0000, 1'b0}, // R5 unseen bits
        '{3'd6, 1'b0, 8'd0,  16'h0000, 16'h0000, 32'h0000_0000, 1'b0}  // R1 bad op
    };

    task automatic chk(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: trig=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic apply(input logic [31:0] p);
        probe = p;
        @(negedge clk);
    endtask

    // slot s select word
    function automatic logic [31:0] selw(input logic [2:0] op, input logic bm, input logic [7:0] lsb);
        return {16'h0, lsb, 4'h0, bm, op};
    endfunction

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk(trig, 1'b0, "R11 reset");
        rst_n = 1'b1;
        probe = '0;
        apply(32'h0000_0000);
        chk(trig, 1'b0, "R11 masks zero");

        wr(5'd0, 32'h1);          // repeat, AND combine
        wr(5'd1, 32'h1);          // slot 0 in AND mask
        foreach (TBL[i]) begin
            probe = '0;
            wr(5'd4, selw(TBL[i].op, TBL[i].bm, TBL[i].lsb));
            wr(5'd5, {16'h0, TBL[i].a});
            wr(5'd6, {16'h0, TBL[i].b});
            apply(TBL[i].p);       // R12 new setup used next cycle
            chk(trig, TBL[i].exp, $sformatf("R1-5 vector %0d", i));
        end

        // Two slots on disjoint fields: slot0 bits[15:0]==1, slot1 bits[31:16]==2
        probe = '0;
        wr(5'd4, selw(3'd0, 1'b0, 8'd0));  wr(5'd5, 32'h1);
        wr(5'd8, selw(3'd0, 1'b0, 8'd16)); wr(5'd9, 32'h2);
        wr(5'd1, 32'h3);
        apply(32'h0002_0001); chk(trig, 1'b1, "R6 and both");
        apply(32'h0002_0000); chk(trig, 1'b0, "R6 and one");
        wr(5'd1, 32'h0);
        apply(32'h0002_0001); chk(trig, 1'b0, "R6 empty and");
        wr(5'd2, 32'h3); wr(5'd0, 32'h3);          // OR only, repeat
        apply(32'h0000_0001); chk(trig, 1'b1, "R7 or one");
        apply(32'h0000_0000); chk(trig, 1'b0, "R7 or none");
        wr(5'd1, 32'h3); wr(5'd2, 32'h1); wr(5'd0, 32'h5); // AND|OR
        apply(32'h0002_0000); chk(trig, 1'b0, "R7 any none");
        apply(32'h0000_0001); chk(trig, 1'b1, "R7 any or-term");
        wr(5'd1, 32'h1); wr(5'd2, 32'h2); wr(5'd0, 32'h7); // AND&OR
        apply(32'h0000_0001); chk(trig, 1'b0, "R7 both one");
        apply(32'h0002_0001); chk(trig, 1'b1, "R7 both");

        // R8 latency and R10 repeat
        wr(5'd0, 32'h1); wr(5'd1, 32'h1); wr(5'd2, 32'h0);
        apply(32'h0);
        probe = 32'h1; #1;
        chk(trig, 1'b0, "R8 not same cycle");
        @(negedge clk); chk(trig, 1'b1, "R8 next cycle");
        apply(32'h1); chk(trig, 1'b1, "R10 repeat 2");
        apply(32'h1); chk(trig, 1'b1, "R10 repeat 3");
        apply(32'h0); chk(trig, 1'b0, "R10 drop");

        // R9 single shot
        wr(5'd0, 32'h100);        // single shot, AND, re-arm
        apply(32'h1); chk(trig, 1'b1, "R9 first hit");
        apply(32'h1); chk(trig, 1'b0, "R9 ignored 1");
        apply(32'h1); chk(trig, 1'b0, "R9 ignored 2");
        probe = 32'h0;
        wr(5'd0, 32'h100);
        apply(32'h1); chk(trig, 1'b1, "R9 after rearm");
        probe = 32'h1;
        wr(5'd0, 32'h100);        // re-arm while firing again
        chk(trig, 1'b0, "R9 disarmed in rearm cycle");
        apply(32'h1); chk(trig, 1'b1, "R9 rearm wins");

        // R11 reset mid-run clears masks
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(32'h1); chk(trig, 1'b0, "R11 cleared by reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: running=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule